// File: doc/BRIEF.md
# Indexed CMOS Clock Register File

This block is a real-time clock with 128 bytes of battery-backed storage behind a pair of byte ports. Software first writes a byte to the index port. Bits 6:0 of that byte select one of 128 locations, and bit 7 drives the `nmi_mask` output. Software then reads or writes the data port. The index port cannot be read back: a read there returns 0xFF and changes nothing. Two status locations cannot be written. Location 0x0D reports valid RAM and time with 0x80, and location 0x0C always reads 0x00. Every other location that is not a clock field is plain storage.

Eight locations return the running time and calendar instead of stored bytes: seconds, minutes, hours, day of week, day of month, month, year within the century, and century. Each comes back as two BCD digits, with tens in bits 7:4 and units in bits 3:0. The `tick` input advances the clock by one second. The carry ripples through the fields under a small state machine, one field per cycle:

- `CK_IDLE` waits for a tick or a held tick, then goes to `CK_SEC`.
- `CK_SEC` goes to `CK_MIN` when seconds wrap at 60, otherwise back to `CK_IDLE`.
- `CK_MIN` goes to `CK_HOUR` when minutes wrap at 60.
- `CK_HOUR` goes to `CK_DAY` when hours wrap at 24.
- `CK_DAY` steps the day of week and goes to `CK_MON` when the day of month passes the month length.
- `CK_MON` goes to `CK_YEAR` when the month wraps past 12.
- `CK_YEAR` goes to `CK_CENT` when the year wraps past 99.
- `CK_CENT` always goes back to `CK_IDLE`.

Top module: `cmos_rtc`

## Requirements
- R1: A write with `addr`=0 loads `wdata[6:0]` as the current index. Accesses with `addr`=1 act on the location that index selects.
- R2: `nmi_mask` equals bit 7 of the most recent index-port write, and is 0 after reset.
- R3: A read with `addr`=0 returns 0xFF on `rdata` and leaves the index and all storage unchanged.
- R4: Data writes to index 0x0C and index 0x0D are ignored. After reset and forever after, 0x0D reads 0x80 and 0x0C reads 0x00.
- R5: At every other index that is not a clock field, a data write stores the byte and a later read returns it. After reset, these locations read 0x00.
- R6: Reads return the live clock as BCD (tens in bits 7:4, units in bits 3:0) at these indices: 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 day of week, 0x07 day of month, 0x08 month, 0x09 year modulo 100, 0x32 century. Data writes to these indices do not change what they read.
- R7: Each `tick` pulse adds one second. Seconds carry into minutes at 60, minutes into hours at 60, and hours into the day at 24.
- R8: On each day rollover, the day of week steps through 1..7 and wraps from 7 to 1. The day of month wraps to 1 after the month's length, and February has 29 days only in Gregorian leap years. Month steps through 1..12 and wraps to 1.
- R9: A month wrap advances the year. A year wrap from 99 to 0 advances the century.
- R10: Synchronous active-low reset loads the parameterised starting date and time. The default is second 0, minute 0, hour 0, day of week 7, day 1, month 1, year 0, century 20.
- R11: `rdata` is updated at the clock edge that samples `rd_en` and holds its value otherwise. A tick settles within 8 cycles. One further tick arriving while a carry is still rippling is held and applied afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-second advance pulse |
| rd_en | input | 1 | Read strobe, single cycle |
| wr_en | input | 1 | Write strobe, single cycle |
| addr | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| nmi_mask | output | 1 | Bit 7 of the last index write |

## Verification
The hardest situations to reach are the rare carries: a year rolling into a new century, February in a century year that is not a leap year, and February in a century year that is. From reset alone, these would take millions of ticks to reach. The bench therefore builds several copies of the block, each with starting-date parameters just seconds before one of these boundaries, and drives them all with the same stimulus. A reference calendar in the bench, written from the requirements, predicts every field after each tick. The bench also drives back-to-back ticks so that a tick arrives while a carry is still rippling.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int IDX_W  = 7;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IX_SEC  = 7'h00;
    localparam logic [IDX_W-1:0] IX_MIN  = 7'h02;
    localparam logic [IDX_W-1:0] IX_HOUR = 7'h04;
    localparam logic [IDX_W-1:0] IX_DOW  = 7'h06;
    localparam logic [IDX_W-1:0] IX_DOM  = 7'h07;
    localparam logic [IDX_W-1:0] IX_MON  = 7'h08;
    localparam logic [IDX_W-1:0] IX_YEAR = 7'h09;
    localparam logic [IDX_W-1:0] IX_CENT = 7'h32;
    localparam logic [IDX_W-1:0] IX_STAT = 7'h0C;
    localparam logic [IDX_W-1:0] IX_VALID = 7'h0D;

    localparam logic [DATA_W-1:0] VALID_INIT = 8'h80;
    localparam logic [DATA_W-1:0] IDX_READ_VAL = 8'hFF;

    typedef enum logic [2:0] {
        CK_IDLE,
        CK_SEC,
        CK_MIN,
        CK_HOUR,
        CK_DAY,
        CK_MON,
        CK_YEAR,
        CK_CENT
    } ck_state_e;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [3:0] mon;
        logic [6:0] yr;
        logic [6:0] cent;
    } rtc_time_t;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v % 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic is_leap(input logic [6:0] yr, input logic [6:0] cent);
        return (yr[1:0] == 2'b00) && ((yr != 7'd0) || (cent[1:0] == 2'b00));
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        logic [4:0] n;
        case (mon)
            4'd2:                       n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    n = 5'd30;
            default:                    n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int unsigned START_SEC  = 0,
    parameter int unsigned START_MIN  = 0,
    parameter int unsigned START_HOUR = 0,
    parameter int unsigned START_DOW  = 7,
    parameter int unsigned START_DOM  = 1,
    parameter int unsigned START_MON  = 1,
    parameter int unsigned START_YEAR = 0,
    parameter int unsigned START_CENT = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    output rtc_time_t now_o,
    output ck_state_e state_o
);

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;
    localparam logic [2:0] DOW_LAST  = 3'd7;
    localparam logic [3:0] MON_LAST  = 4'd12;
    localparam logic [6:0] YR_LAST   = 7'd99;
    localparam logic [6:0] CENT_LAST = 7'd99;

    ck_state_e state_q, state_d;
    logic      pend_q, pend_d;
    rtc_time_t t_q;
    logic [4:0] mlen;

    assign mlen = month_len(t_q.mon, is_leap(t_q.yr, t_q.cent));

    // next-state logic of the carry ripple
    always_comb begin
        state_d = CK_IDLE;
        unique case (state_q)
            CK_IDLE: state_d = (tick_i || pend_q) ? CK_SEC : CK_IDLE;
            CK_SEC:  state_d = (t_q.sec  == SEC_LAST)  ? CK_MIN  : CK_IDLE;
            CK_MIN:  state_d = (t_q.min  == MIN_LAST)  ? CK_HOUR : CK_IDLE;
            CK_HOUR: state_d = (t_q.hour == HOUR_LAST) ? CK_DAY  : CK_IDLE;
            CK_DAY:  state_d = (t_q.dom  == mlen)      ? CK_MON  : CK_IDLE;
            CK_MON:  state_d = (t_q.mon  == MON_LAST)  ? CK_YEAR : CK_IDLE;
            CK_YEAR: state_d = (t_q.yr   == YR_LAST)   ? CK_CENT : CK_IDLE;
            CK_CENT: state_d = CK_IDLE;
            default: state_d = CK_IDLE;
        endcase
        if (state_q == CK_IDLE) begin
            pend_d = pend_q && tick_i;
        end else begin
            pend_d = pend_q || tick_i;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CK_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // field updates, one field per state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.sec  <= 6'(START_SEC);
            t_q.min  <= 6'(START_MIN);
            t_q.hour <= 5'(START_HOUR);
            t_q.dow  <= 3'(START_DOW);
            t_q.dom  <= 5'(START_DOM);
            t_q.mon  <= 4'(START_MON);
            t_q.yr   <= 7'(START_YEAR);
            t_q.cent <= 7'(START_CENT);
        end else begin
            unique case (state_q)
                CK_IDLE: ;
                CK_SEC:  t_q.sec  <= (t_q.sec  == SEC_LAST)  ? 6'd0 : t_q.sec + 6'd1;
                CK_MIN:  t_q.min  <= (t_q.min  == MIN_LAST)  ? 6'd0 : t_q.min + 6'd1;
                CK_HOUR: t_q.hour <= (t_q.hour == HOUR_LAST) ? 5'd0 : t_q.hour + 5'd1;
                CK_DAY: begin
                    t_q.dow <= (t_q.dow == DOW_LAST) ? 3'd1 : t_q.dow + 3'd1;
                    t_q.dom <= (t_q.dom == mlen)     ? 5'd1 : t_q.dom + 5'd1;
                end
                CK_MON:  t_q.mon  <= (t_q.mon  == MON_LAST)  ? 4'd1 : t_q.mon + 4'd1;
                CK_YEAR: t_q.yr   <= (t_q.yr   == YR_LAST)   ? 7'd0 : t_q.yr + 7'd1;
                CK_CENT: t_q.cent <= (t_q.cent == CENT_LAST) ? 7'd0 : t_q.cent + 7'd1;
                default: ;
            endcase
        end
    end

    assign now_o   = t_q;
    assign state_o = state_q;

endmodule

// File: rtl/rtc_store.sv
module rtc_store
    import rtc_pkg::*;
#(
    parameter int DEPTH_P = DEPTH,
    parameter int AW      = $clog2(DEPTH_P)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH_P];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH_P; i++) begin
                mem[i] <= (i == int'(IX_VALID)) ? VALID_INIT : '0;
            end
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/rtc_port.sv
module rtc_port
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  rtc_time_t         now,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [DATA_W-1:0] rdata,
    output logic              nmi_mask
);

    localparam logic PORT_INDEX = 1'b0;
    localparam logic PORT_DATA  = 1'b1;

    logic [IDX_W-1:0]  idx_q;
    logic              nmi_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic              protected_idx;

    // index port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            nmi_q <= 1'b0;
        end else if (wr_en && addr == PORT_INDEX) begin
            idx_q <= wdata[IDX_W-1:0];
            nmi_q <= wdata[DATA_W-1];
        end
    end

    assign protected_idx = (idx_q == IX_STAT) || (idx_q == IX_VALID);
    assign ram_we = wr_en && (addr == PORT_DATA) && !protected_idx;

    // data read selection: clock fields override storage
    always_comb begin
        case (idx_q)
            IX_SEC:  rd_mux = to_bcd(7'(now.sec));
            IX_MIN:  rd_mux = to_bcd(7'(now.min));
            IX_HOUR: rd_mux = to_bcd(7'(now.hour));
            IX_DOW:  rd_mux = to_bcd(7'(now.dow));
            IX_DOM:  rd_mux = to_bcd(7'(now.dom));
            IX_MON:  rd_mux = to_bcd(7'(now.mon));
            IX_YEAR: rd_mux = to_bcd(now.yr);
            IX_CENT: rd_mux = to_bcd(now.cent);
            default: rd_mux = ram_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= (addr == PORT_INDEX) ? IDX_READ_VAL : rd_mux;
        end
    end

    assign cur_idx  = idx_q;
    assign rdata    = rdata_q;
    assign nmi_mask = nmi_q;

endmodule

// File: rtl/cmos_rtc.sv
module cmos_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned START_SEC  = 0,
    parameter int unsigned START_MIN  = 0,
    parameter int unsigned START_HOUR = 0,
    parameter int unsigned START_DOW  = 7,
    parameter int unsigned START_DOM  = 1,
    parameter int unsigned START_MON  = 1,
    parameter int unsigned START_YEAR = 0,
    parameter int unsigned START_CENT = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       nmi_mask
);

    rtc_time_t         now;
    ck_state_e         ck_state;
    logic              ram_we;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] ram_rdata;

    rtc_calendar #(
        .START_SEC (START_SEC),
        .START_MIN (START_MIN),
        .START_HOUR(START_HOUR),
        .START_DOW (START_DOW),
        .START_DOM (START_DOM),
        .START_MON (START_MON),
        .START_YEAR(START_YEAR),
        .START_CENT(START_CENT)
    ) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .now_o  (now),
        .state_o(ck_state)
    );

    rtc_store #(
        .DEPTH_P(DEPTH)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .idx  (cur_idx),
        .wdata(wdata),
        .rdata(ram_rdata)
    );

    rtc_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .now      (now),
        .ram_rdata(ram_rdata),
        .ram_we   (ram_we),
        .cur_idx  (cur_idx),
        .rdata    (rdata),
        .nmi_mask (nmi_mask)
    );

endmodule

// File: rtl/cmos_rtc_checker.sv
module cmos_rtc_checker
    import rtc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic             addr,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input logic             nmi_mask,
    input logic [IDX_W-1:0] cur_idx,
    input rtc_time_t        now,
    input ck_state_e        ck_state
);

    logic clock_idx;
    assign clock_idx = (cur_idx == IX_SEC) || (cur_idx == IX_MIN) || (cur_idx == IX_HOUR) ||
                       (cur_idx == IX_DOW) || (cur_idx == IX_DOM) || (cur_idx == IX_MON) ||
                       (cur_idx == IX_YEAR) || (cur_idx == IX_CENT);

    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (cur_idx == $past(wdata[6:0])));

    a_r2_nmi_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (nmi_mask == $past(wdata[7])));

    a_r3_index_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr) |=> (rdata == 8'hFF));

    a_r3_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !addr) |=> $stable(cur_idx));

    a_r4_valid_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr && cur_idx == IX_VALID) |=> (rdata == 8'h80));

    a_r4_status_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr && cur_idx == IX_STAT) |=> (rdata == 8'h00));

    a_r6_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr && clock_idx) |=> (rdata[7:4] <= 4'd9 && rdata[3:0] <= 4'd9));

    a_r7_time_ranges: assert property (@(posedge clk) disable iff (!rst_n)
        (now.sec < 6'd60) && (now.min < 6'd60) && (now.hour < 5'd24));

    a_r8_date_ranges: assert property (@(posedge clk) disable iff (!rst_n)
        (now.dow >= 3'd1) && (now.dow <= 3'd7) && (now.dom >= 5'd1) &&
        (now.mon >= 4'd1) && (now.mon <= 4'd12));

    a_r9_century_only_after_year: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_state == CK_CENT) |-> ($past(ck_state) == CK_YEAR));

    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind cmos_rtc cmos_rtc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .nmi_mask(nmi_mask),
    .cur_idx (cur_idx),
    .now     (now),
    .ck_state(ck_state)
);

// File: tb/cmos_rtc_test.sv
`timescale 1ns/1ps
module cmos_rtc_test;

    localparam int NI = 4;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic rd_en = 1'b0;
    logic wr_en = 1'b0;
    logic addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdq [NI];
    logic       nmq [NI];

    always #5 clk = ~clk;

    // 0: end of century, 1: Feb in a non-leap century year,
    // 2: Feb in a leap century year, 3: default start
    cmos_rtc #(.START_SEC(30), .START_MIN(59), .START_HOUR(23), .START_DOW(5),
               .START_DOM(31), .START_MON(12), .START_YEAR(99), .START_CENT(20)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdq[0]), .nmi_mask(nmq[0]));
    cmos_rtc #(.START_SEC(50), .START_MIN(59), .START_HOUR(23), .START_DOW(1),
               .START_DOM(28), .START_MON(2), .START_YEAR(0), .START_CENT(21)) uut_b (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdq[1]), .nmi_mask(nmq[1]));
    cmos_rtc #(.START_SEC(50), .START_MIN(59), .START_HOUR(23), .START_DOW(2),
               .START_DOM(28), .START_MON(2), .START_YEAR(0), .START_CENT(20)) uut_c (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdq[2]), .nmi_mask(nmq[2]));
    cmos_rtc uut_d (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdq[3]), .nmi_mask(nmq[3]));

    int m_sec [NI] = '{30, 50, 50, 0};
    int m_min [NI] = '{59, 59, 59, 0};
    int m_hour[NI] = '{23, 23, 23, 0};
    int m_dow [NI] = '{5, 1, 2, 7};
    int m_dom [NI] = '{31, 28, 28, 1};
    int m_mon [NI] = '{12, 2, 2, 1};
    int m_yr  [NI] = '{99, 0, 0, 0};
    int m_cent[NI] = '{20, 21, 20, 20};
    int fidx  [8]  = '{0, 2, 4, 6, 7, 8, 9, 50};

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    function automatic int bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int mdays(input int m, input int y, input int c);
        bit lp;
        lp = (y % 4 == 0) && (y != 0 || c % 4 == 0);
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic bit is_clock(input int i);
        return i == 0 || i == 2 || i == 4 || i == 6 || i == 7 || i == 8 || i == 9 || i == 50;
    endfunction

    function automatic int pat(input int i);
        return (i * 37 + 5) & 255;
    endfunction

    function automatic int field(input int k, input int i);
        case (i)
            0: return bcd(m_sec[k]);
            2: return bcd(m_min[k]);
            4: return bcd(m_hour[k]);
            6: return bcd(m_dow[k]);
            7: return bcd(m_dom[k]);
            8: return bcd(m_mon[k]);
            9: return bcd(m_yr[k]);
            default: return bcd(m_cent[k]);
        endcase
    endfunction

    task automatic model_tick();
        for (int k = 0; k < NI; k++) begin
            m_sec[k]++;
            if (m_sec[k] == 60) begin
                m_sec[k] = 0; m_min[k]++;
                if (m_min[k] == 60) begin
                    m_min[k] = 0; m_hour[k]++;
                    if (m_hour[k] == 24) begin
                        m_hour[k] = 0;
                        m_dow[k] = (m_dow[k] == 7) ? 1 : m_dow[k] + 1;
                        m_dom[k]++;
                        if (m_dom[k] > mdays(m_mon[k], m_yr[k], m_cent[k])) begin
                            m_dom[k] = 1; m_mon[k]++;
                            if (m_mon[k] == 13) begin
                                m_mon[k] = 1; m_yr[k]++;
                                if (m_yr[k] == 100) begin
                                    m_yr[k] = 0;
                                    m_cent[k] = (m_cent[k] == 99) ? 0 : m_cent[k] + 1;
                                end
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic set_index(input int v);
        @(negedge clk);
        wr_en = 1'b1; addr = 1'b0; wdata = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_data(input int v);
        @(negedge clk);
        wr_en = 1'b1; addr = 1'b1; wdata = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_clock(input string req);
        for (int f = 0; f < 8; f++) begin
            set_index(fidx[f]);
            do_read(1'b1);
            for (int k = 0; k < NI; k++) check(req, rdq[k], field(k, fidx[f]));
        end
    endtask

    task automatic pulse_ticks(input int n, input int settle);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        repeat (settle) @(negedge clk);
        repeat (n) model_tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R11 actual=%0d cycles expected=<%0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R2, R10, R4, R5
        for (int k = 0; k < NI; k++) check("R2 nmi after reset", nmq[k], 0);
        check_clock("R10 reset date");
        set_index(8'h0D); do_read(1'b1);
        for (int k = 0; k < NI; k++) check("R4 valid flag after reset", rdq[k], 8'h80);
        set_index(8'h0C); do_read(1'b1);
        for (int k = 0; k < NI; k++) check("R4 status C after reset", rdq[k], 8'h00);
        set_index(8'h10); do_read(1'b1);
        for (int k = 0; k < NI; k++) check("R5 RAM after reset", rdq[k], 8'h00);

        // write sweep across all 128 indices, bit 7 toggles the mask (R1, R2)
        for (int i = 0; i < 128; i++) begin
            set_index(i | ((i & 1) << 7));
            for (int k = 0; k < NI; k++) check("R2 nmi from index bit7", nmq[k], i & 1);
            write_data(pat(i));
        end
        // read sweep (R1, R4, R5, R6)
        for (int i = 0; i < 128; i++) begin
            set_index(i);
            do_read(1'b1);
            for (int k = 0; k < NI; k++) begin
                if (is_clock(i))    check("R6 clock ignores write", rdq[k], field(k, i));
                else if (i == 12)   check("R4 status C write ignored", rdq[k], 8'h00);
                else if (i == 13)   check("R4 valid D write ignored", rdq[k], 8'h80);
                else                check("R5 RAM readback", rdq[k], pat(i));
            end
        end

        // index port read: 0xFF, index untouched (R3)
        set_index(8'h20);
        do_read(1'b0);
        for (int k = 0; k < NI; k++) check("R3 index read value", rdq[k], 8'hFF);
        do_read(1'b1);
        for (int k = 0; k < NI; k++) check("R3 index kept after index read", rdq[k], pat(32));

        // rdata holds while no read strobe (R11)
        held = rdq[0];
        set_index(8'h00);
        repeat (4) @(negedge clk);
        check("R11 rdata held", rdq[0], held);

        // single ticks across day, month, year and century boundaries (R7, R8, R9)
        for (int t = 0; t < 150; t++) begin
            pulse_ticks(1, 10);
            check_clock("R7 R8 R9 tick sweep");
        end

        // back-to-back ticks, second one held during the ripple (R11)
        for (int t = 0; t < 6; t++) begin
            pulse_ticks(2, 20);
            check_clock("R11 held tick");
        end

        // reset restores start date and protected values (R10, R4)
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        m_sec  = '{30, 50, 50, 0};  m_min = '{59, 59, 59, 0};
        m_hour = '{23, 23, 23, 0};  m_dow = '{5, 1, 2, 7};
        m_dom  = '{31, 28, 28, 1};  m_mon = '{12, 2, 2, 1};
        m_yr   = '{99, 0, 0, 0};    m_cent = '{20, 21, 20, 20};
        check_clock("R10 date after second reset");
        set_index(8'h0D); write_data(8'h00); do_read(1'b1);
        for (int k = 0; k < NI; k++) check("R4 valid flag survives write", rdq[k], 8'h80);

        done = 1;
        summary();
        $finish;
    end

endmodule